// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block divides a VCO-rate input clock by a programmable fractional ratio and produces the feedback pulse for a synthesizer loop. Each output period has B prescaler sweeps. The first A sweeps last P+1 input cycles and the remaining sweeps last P cycles. The modulus P is 4 or 8, chosen by a band bit. A first-order accumulator adds the fractional numerator once per period, modulo a denominator. Each time it wraps, one input cycle is added to the last sweep, so the long-run average ratio is P·B + A + FN/FD.

The denominator is not a power of two. It is looked up inside the block from the band bit, the receive/transmit bit and the 2-bit reference select. The block also reports the reference divider that matches the reference select. New ratio settings are sampled only at a period boundary. A setting that breaks the legal ranges is rejected: an error flag is raised and the last accepted ratio keeps running.

Top module: `fracdiv_top`

## Requirements
- R1: The number of input cycles from one divPulse to the next equals P·B + A + c, where P is 4 when bandSel=0 and 8 when bandSel=1, and c (0 or 1) is the accumulator wrap for that period.
- R2: Under a constant accepted setting, the accumulator starts at 0 and adds FN once per period. It wraps (c=1) whenever the sum reaches FD and then subtracts FD. Over FD periods, exactly FN extra input cycles are added.
- R3: The denominator FD depends on the reference select (00, 01, 10, 11) as follows. For receive (txSel=0) in either band, FD is 504, 576, 504, 520. For transmit in band 0, FD is 630, 720, 630, 650. For transmit in band 1, FD is 567, 648, 567, 585.
- R4: A setting is legal when all of these hold: 2 ≤ B ≤ 15, A < B, A ≤ 3 in band 0 or A ≤ 7 in band 1, and FN < FD.
- R5: cfgError shows the legality of the setting sampled at the most recent boundary (1 = rejected). A rejected setting leaves the previously accepted ratio in use, and cfgError changes only in the cycle after a boundary.
- R6: Inputs are sampled only on the clock edge that ends a divPulse cycle. Changes made during a period do not alter that period's length.
- R7: rDiv is 1 for reference select 00 and 01, and 2 for 10 and 11. It follows the accepted setting and changes only after a boundary.
- R8: During reset divPulse=0, cfgError=0 and rDiv=1. The first period is loaded on the first clock edge after reset, and the first divPulse comes P·B + A + c cycles after that edge's cycle.
- R9: The accumulator restarts from 0 when an accepted setting has a different FD from the one in use.
- R10: divPulse is high for exactly one input cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rstN | input | 1 | Active-low synchronous reset |
| progB | input | 4 | Program count B (prescaler sweeps per period) |
| swalA | input | 3 | Swallow count A (sweeps at P+1) |
| fracN | input | 10 | Fractional numerator FN |
| bandSel | input | 1 | Band select: 0 gives P=4, 1 gives P=8 |
| txSel | input | 1 | 0 = receive spacing, 1 = transmit spacing |
| refSel | input | 2 | Reference select, used for FD and the R divider |
| divPulse | output | 1 | One-cycle feedback pulse at the end of each period |
| rDiv | output | 2 | Reference divider value (1 or 2) |
| cfgError | output | 1 | Last sampled setting was rejected |

## Verification
divPulse is the last cycle of a period, so a period's length is the count of falling edges from one pulse to the next. The bench counts exactly that for every period and compares it with its own model of B, A, P and the wrap. Inputs are driven at the falling edge inside a pulse cycle, so the rising edge that follows loads them. cfgError and rDiv sit one register after that edge, so the bench samples them at the first falling edge after the pulse. It also checks there that divPulse has already dropped. For mid-period changes, the inputs are altered three cycles into a period, and the bench expects the old length for that period and the new one for the next.

// File: rtl/fracdiv_pkg.sv
`timescale 1ns/1ps
package fracdiv_pkg;
  localparam int B_W  = 4;
  localparam int A_W  = 3;
  localparam int FN_W = 10;

  typedef struct packed {
    logic [B_W-1:0]  progB;
    logic [A_W-1:0]  swalA;
    logic [FN_W-1:0] fracN;
    logic            band;
    logic            tx;
    logic [1:0]      refSel;
  } ratio_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic carry;
  } dpCtl_t;

  // channel denominator by band / direction / reference
  function automatic logic [FN_W-1:0] denomLookup(input logic band, input logic tx,
                                                  input logic [1:0] refSel);
    logic [FN_W-1:0] d;
    unique case ({tx, band, refSel})
      4'b0000, 4'b0100: d = FN_W'(504);
      4'b0001, 4'b0101: d = FN_W'(576);
      4'b0010, 4'b0110: d = FN_W'(504);
      4'b0011, 4'b0111: d = FN_W'(520);
      4'b1000:          d = FN_W'(630);
      4'b1001:          d = FN_W'(720);
      4'b1010:          d = FN_W'(630);
      4'b1011:          d = FN_W'(650);
      4'b1100:          d = FN_W'(567);
      4'b1101:          d = FN_W'(648);
      4'b1110:          d = FN_W'(567);
      default:          d = FN_W'(585);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fracdiv_ctrl.sv
`timescale 1ns/1ps
module fracdiv_ctrl
  import fracdiv_pkg::*;
#(
  parameter int A_MAX_LO = 3,
  parameter int A_MAX_HI = 7,
  parameter int B_MIN    = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ratio_t          reqCfg,
  input  logic            periodEnd,
  output dpCtl_t          dpCtl,
  output logic [B_W-1:0]  ldB,
  output logic [A_W-1:0]  ldA,
  output logic            ldBand,
  output logic            cfgError,
  output logic [1:0]      rDiv
);
  localparam logic [A_W-1:0] A_LIM_LO = A_W'(A_MAX_LO);
  localparam logic [A_W-1:0] A_LIM_HI = A_W'(A_MAX_HI);
  localparam logic [B_W-1:0] B_LIM    = B_W'(B_MIN);

  ratio_t          heldCfg, useCfg;
  logic [FN_W-1:0] acc, accBase, accNext, reqFd, heldFd, useFd;
  logic [FN_W:0]   sum;
  logic [A_W-1:0]  aMax;
  logic            reqOk, carry;

  assign reqFd  = denomLookup(reqCfg.band, reqCfg.tx, reqCfg.refSel);
  assign heldFd = denomLookup(heldCfg.band, heldCfg.tx, heldCfg.refSel);
  assign aMax   = reqCfg.band ? A_LIM_HI : A_LIM_LO;

  always_comb begin
    reqOk = (reqCfg.progB >= B_LIM) && (reqCfg.swalA < reqCfg.progB) &&
            (reqCfg.swalA <= aMax) && (reqCfg.fracN < reqFd);
    useCfg  = reqOk ? reqCfg : heldCfg;
    useFd   = reqOk ? reqFd : heldFd;
    accBase = (reqOk && (reqFd != heldFd)) ? '0 : acc;
    sum     = {1'b0, accBase} + {1'b0, useCfg.fracN};
    carry   = sum >= {1'b0, useFd};
    accNext = carry ? FN_W'(sum - {1'b0, useFd}) : FN_W'(sum);
  end

  assign dpCtl.load  = periodEnd;
  assign dpCtl.carry = carry;
  assign ldB    = useCfg.progB;
  assign ldA    = useCfg.swalA;
  assign ldBand = useCfg.band;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCfg  <= '{progB: B_LIM, swalA: '0, fracN: '0, band: 1'b0, tx: 1'b0, refSel: 2'b00};
      acc      <= '0;
      cfgError <= 1'b0;
      rDiv     <= 2'd1;
    end else if (periodEnd) begin
      heldCfg  <= useCfg;
      acc      <= accNext;
      cfgError <= !reqOk;
      rDiv     <= useCfg.refSel[1] ? 2'd2 : 2'd1;
    end
  end
endmodule

// File: rtl/fracdiv_dp.sv
`timescale 1ns/1ps
module fracdiv_dp
  import fracdiv_pkg::*;
#(
  parameter int P_LO = 4,
  parameter int P_HI = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [B_W-1:0] ldB,
  input  logic [A_W-1:0] ldA,
  input  logic           ldBand,
  output logic           periodEnd,
  output logic           divPulse
);
  localparam int PRE_W = $clog2(P_HI + 2);
  localparam logic [PRE_W-1:0] MOD_LO = PRE_W'(P_LO);
  localparam logic [PRE_W-1:0] MOD_HI = PRE_W'(P_HI);

  logic [PRE_W-1:0] preCnt, ldMod, runMod;
  logic [B_W-1:0]   bRem;
  logic [A_W-1:0]   aRem;
  logic             carryQ, bandQ, primed, sweepEnd;

  assign ldMod     = ldBand ? MOD_HI : MOD_LO;
  assign runMod    = bandQ ? MOD_HI : MOD_LO;
  assign sweepEnd  = (preCnt == '0);
  assign periodEnd = sweepEnd && (bRem == '0);
  assign divPulse  = periodEnd && primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      bRem   <= '0;
      aRem   <= '0;
      carryQ <= 1'b0;
      bandQ  <= 1'b0;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (ctl.load) begin
        // first sweep swallows one cycle when A is non-zero
        preCnt <= (ldA != '0) ? ldMod : ldMod - 1'b1;
        bRem   <= ldB - 1'b1;
        aRem   <= (ldA != '0) ? ldA - 1'b1 : '0;
        carryQ <= ctl.carry;
        bandQ  <= ldBand;
      end else if (sweepEnd) begin
        bRem <= bRem - 1'b1;
        if (bRem == B_W'(1)) begin
          // last sweep carries the fractional extra cycle
          preCnt <= carryQ ? runMod : runMod - 1'b1;
        end else if (aRem != '0) begin
          preCnt <= runMod;
          aRem   <= aRem - 1'b1;
        end else begin
          preCnt <= runMod - 1'b1;
        end
      end else begin
        preCnt <= preCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fracdiv_top.sv
`timescale 1ns/1ps
module fracdiv_top
  import fracdiv_pkg::*;
#(
  parameter int P_LO     = 4,
  parameter int P_HI     = 8,
  parameter int A_MAX_LO = 3,
  parameter int A_MAX_HI = 7,
  parameter int B_MIN    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [B_W-1:0]   progB,
  input  logic [A_W-1:0]   swalA,
  input  logic [FN_W-1:0]  fracN,
  input  logic             bandSel,
  input  logic             txSel,
  input  logic [1:0]       refSel,
  output logic             divPulse,
  output logic [1:0]       rDiv,
  output logic             cfgError
);
  ratio_t         reqCfg;
  dpCtl_t         dpCtl;
  logic [B_W-1:0] ldB;
  logic [A_W-1:0] ldA;
  logic           ldBand, periodEnd;

  assign reqCfg = '{progB: progB, swalA: swalA, fracN: fracN,
                    band: bandSel, tx: txSel, refSel: refSel};

  fracdiv_ctrl #(.A_MAX_LO(A_MAX_LO), .A_MAX_HI(A_MAX_HI), .B_MIN(B_MIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqCfg(reqCfg), .periodEnd(periodEnd),
    .dpCtl(dpCtl), .ldB(ldB), .ldA(ldA), .ldBand(ldBand),
    .cfgError(cfgError), .rDiv(rDiv)
  );

  fracdiv_dp #(.P_LO(P_LO), .P_HI(P_HI)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .ldB(ldB), .ldA(ldA), .ldBand(ldBand),
    .periodEnd(periodEnd), .divPulse(divPulse)
  );
endmodule

// File: rtl/fracdiv_sva.sv
`timescale 1ns/1ps
module fracdiv_sva #(
  parameter int P_LO = 4,
  parameter int P_HI = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       divPulse,
  input logic       cfgError,
  input logic [1:0] rDiv
);
  localparam int GAP_MIN = 2 * P_LO;
  localparam int GAP_MAX = 15 * P_HI + P_HI;
  localparam int GAP_W   = $clog2(GAP_MAX + 2) + 1;

  logic             armed;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      gap   <= '0;
    end else begin
      armed <= 1'b1;
      gap   <= divPulse ? GAP_W'(1) : gap + 1'b1;
    end
  end

  p_pulse_narrow_r10: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  p_err_at_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !divPulse) |=> $stable(cfgError));

  p_rdiv_at_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !divPulse) |=> $stable(rDiv));

  p_rdiv_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rDiv == 2'd1) || (rDiv == 2'd2));

  p_period_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> ((int'(gap) >= GAP_MIN) && (int'(gap) <= GAP_MAX)));
endmodule

bind fracdiv_top fracdiv_sva #(.P_LO(P_LO), .P_HI(P_HI)) sva_i (
  .clk(clk), .rstN(rstN), .divPulse(divPulse), .cfgError(cfgError), .rDiv(rDiv)
);

// File: tb/fracdiv_top_tb_top.sv
`timescale 1ns/1ps
module fracdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] progB;
  logic [2:0] swalA;
  logic [9:0] fracN;
  logic       bandSel, txSel;
  logic [1:0] refSel;
  logic       divPulse, cfgError;
  logic [1:0] rDiv;

  always #2.5 clk = ~clk;

  fracdiv_top dut_i (
    .clk(clk), .rstN(rstN), .progB(progB), .swalA(swalA), .fracN(fracN),
    .bandSel(bandSel), .txSel(txSel), .refSel(refSel),
    .divPulse(divPulse), .rDiv(rDiv), .cfgError(cfgError)
  );

  int checks = 0, errors = 0, cycles = 0, lastN = 0;
  bit done = 1'b0;
  // independent model state
  int mB = 2, mA = 0, mFn = 0, mBand = 0, mTx = 0, mRef = 0, mAcc = 0;
  // values applied mid-period
  logic [3:0] altB;
  logic [2:0] altA;
  logic       altBand;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // FD from reference frequency (kHz), R divider and channel spacing
  function automatic int fdCalc(int band, int tx, int rf);
    int kHz = (rf == 0) ? 12600 : (rf == 1) ? 14400 : (rf == 2) ? 25200 : 26000;
    int r   = (rf >= 2) ? 2 : 1;
    if (tx == 0) return kHz / (25 * r);
    if (band == 0) return kHz / (20 * r);
    return (kHz * 9) / (200 * r);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(output int expN, output int expErr, output int expR);
    int b, a, fn, bd, tx, rf, fdNew, fdUse, carry;
    bit ok;
    b = int'(progB); a = int'(swalA); fn = int'(fracN);
    bd = int'(bandSel); tx = int'(txSel); rf = int'(refSel);
    fdNew = fdCalc(bd, tx, rf);
    ok = (b >= 2) && (a < b) && (a <= (bd ? 7 : 3)) && (fn < fdNew);
    if (ok) begin
      if (fdNew != fdCalc(mBand, mTx, mRef)) mAcc = 0;
      mB = b; mA = a; mFn = fn; mBand = bd; mTx = tx; mRef = rf;
    end
    fdUse = fdCalc(mBand, mTx, mRef);
    mAcc += mFn;
    carry = (mAcc >= fdUse) ? 1 : 0;
    if (carry != 0) mAcc -= fdUse;
    expN   = (mBand != 0 ? 8 : 4) * mB + mA + carry;
    expErr = ok ? 0 : 1;
    expR   = (mRef >= 2) ? 2 : 1;
  endtask

  // called at the falling edge inside a pulse cycle, inputs already set
  task automatic measure(string tag, bit mid);
    int expN, expErr, expR, n;
    modelStep(expN, expErr, expR);
    @(negedge clk);
    n = 1;
    chk({tag, " pulse one cycle wide R10"}, int'(divPulse), 0);
    chk({tag, " cfgError R5"}, int'(cfgError), expErr);
    chk({tag, " rDiv R7"}, int'(rDiv), expR);
    while (!divPulse && n < 400) begin
      if (mid && n == 3) begin
        progB = altB; swalA = altA; bandSel = altBand;
      end
      @(negedge clk);
      n++;
    end
    chk({tag, " period length"}, n, expN);
    lastN = n;
  endtask

  task automatic setCfg(int b, int a, int fn, int bd, int tx, int rf);
    progB = 4'(b); swalA = 3'(a); fracN = 10'(fn);
    bandSel = bd[0]; txSel = tx[0]; refSel = 2'(rf);
  endtask

  initial begin
    int expN, expErr, expR, n, total;
    setCfg(2, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 divPulse in reset", int'(divPulse), 0);
    chk("R8 cfgError in reset", int'(cfgError), 0);
    chk("R8 rDiv in reset", int'(rDiv), 1);
    rstN = 1'b1;
    #1;
    chk("R8 no pulse before first load", int'(divPulse), 0);
    modelStep(expN, expErr, expR);
    n = 0;
    while (!divPulse && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R8 first period after reset", n, expN);

    // R1 sweep of every legal integer ratio, both bands
    for (int bd = 0; bd < 2; bd++)
      for (int b = 2; b < 16; b++)
        for (int a = 0; a <= (bd != 0 ? 7 : 3); a++)
          if (a < b) begin
            setCfg(b, a, 0, bd, 0, 0);
            measure("R1 ratio sweep", 1'b0);
          end

    // R4 / R5 rejection with hold of last legal ratio
    setCfg(5, 2, 100, 0, 0, 0); measure("R4 legal base", 1'b0);
    setCfg(1, 0, 100, 0, 0, 0); measure("R4 reject B=1", 1'b0);
    setCfg(0, 0, 100, 0, 0, 0); measure("R4 reject B=0", 1'b0);
    setCfg(5, 5, 100, 1, 0, 0); measure("R4 reject A=B", 1'b0);
    setCfg(10, 4, 100, 0, 0, 0); measure("R4 reject A=4 in band 0", 1'b0);
    setCfg(10, 2, 504, 0, 0, 0); measure("R4 reject FN=FD", 1'b0);
    setCfg(9, 7, 3, 1, 0, 0); measure("R5 legal again", 1'b0);

    // R3 denominator boundary for every band/direction/reference
    for (int bd = 0; bd < 2; bd++)
      for (int tx = 0; tx < 2; tx++)
        for (int rf = 0; rf < 4; rf++) begin
          setCfg(2, 0, fdCalc(bd, tx, rf) - 1, bd, tx, rf);
          measure("R3 FN=FD-1 accepted", 1'b0);
          setCfg(2, 0, fdCalc(bd, tx, rf), bd, tx, rf);
          measure("R3 FN=FD rejected", 1'b0);
        end

    // R6 mid-period change
    setCfg(6, 1, 0, 0, 0, 0); measure("R6 setup", 1'b0);
    altB = 4'd12; altA = 3'd3; altBand = 1'b1;
    measure("R6 mid-period change ignored", 1'b1);
    measure("R6 new ratio at next boundary", 1'b0);

    // R2 dither over one full denominator cycle
    setCfg(3, 1, 7, 1, 1, 3);
    total = 0;
    for (int k = 0; k < 585; k++) begin
      measure("R2 dither", 1'b0);
      total += lastN;
    end
    chk("R2 extra cycles over FD periods", total, 585 * 25 + 7);
    repeat (3) measure("R2 dither tail", 1'b0);

    // R9 accumulator restart on denominator change
    setCfg(2, 0, 719, 0, 1, 1);
    measure("R9 first period after FD change", 1'b0);
    measure("R9 second period after FD change", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule